// File: doc/BRIEF.md
# Single-Cycle Integer Core (Eight-Instruction Subset)

This block is a 32-bit processor core that completes one instruction per clock. Each cycle it presents its program counter on the instruction port and decodes the returned word. It reads up to two operands from a 32 x 32 register file and adds or subtracts them. It then either writes a register, performs a data access, or redirects the program counter. The instruction set is deliberately narrow: register add and subtract, add-immediate, word and byte loads and stores, and the two equality branches. Every other encoding executes as a no-op.

Data accesses go through a separate load/store unit. The core drives an address, write data and a byte/word flag, and raises a read or write strobe. In the same cycle the unit returns read data combinationally. For a byte access the unit moves the addressed byte to and from bits [7:0]. Two instruction layouts are decoded. Both start with a 6-bit opcode, a 5-bit first source field and a 5-bit second register field. In the register layout the second field is a source and bits [15:11] name the destination. In the immediate layout the second field is the destination (or the store data source) and bits [15:0] hold a signed constant.

Top module: `mini_core`

## Requirements
- R1: Opcode 000000 with shift bits [10:6] zero and function 100000 writes rs+rt into register rd (bits [15:11]). Function 100010 writes rs-rt instead. Both results wrap modulo 2^32.
- R2: Opcode 001000 writes rs plus the sign-extended 16-bit constant into register rt (bits [20:16]).
- R3: Register 0 reads as zero in every cycle, and any write aimed at it is dropped.
- R4: Opcode 100011 loads the word at rs + sign-extended constant into rt. Opcode 101011 stores rt to that address. Both hold ls_byte low and drive the sum on ls_addr.
- R5: Opcode 100000 loads ls_rdata[7:0], sign-extended, into rt and ignores ls_rdata[31:8]. Opcode 101000 stores rt[7:0] on ls_wdata[7:0]. Both hold ls_byte high.
- R6: Opcode 000100 (taken when rs equals rt) and opcode 000101 (taken when they differ) set the next PC to PC+4 plus the sign-extended constant shifted left by two. When not taken, the next PC is PC+4.
- R7: Any other opcode, or opcode 000000 with another function or a nonzero shift field, writes no register, raises neither ls_we nor ls_re, and advances the PC by 4.
- R8: A synchronous active-high rst sets the PC to 0. While rst is high no register is written and neither data strobe is raised.
- R9: imem_addr always equals the PC, and any instruction other than a branch advances it by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (current PC) |
| imem_data | input | 32 | Instruction word at imem_addr |
| ls_addr | output | 32 | Data access byte address |
| ls_wdata | output | 32 | Store data (byte stores use bits [7:0]) |
| ls_we | output | 1 | Store strobe |
| ls_re | output | 1 | Load strobe |
| ls_byte | output | 1 | High for a byte access, low for a word |
| ls_rdata | input | 32 | Load data returned in the same cycle |

## Verification
Several properties hold on every cycle and are asserted continuously. Register 0 must read as zero. The next PC must be PC+4 for a non-branch instruction, or the branch target for a taken branch. A store strobe may appear only under a store opcode. The data address must always be base plus constant. Reset must hold the PC at zero with the strobes quiet. Register contents, write-back of arithmetic and load results, dropped writes to register 0, byte sign extension, and the silence of unsupported encodings are invisible at the ports until a later store exposes them. Those are shown only by the bench's directed programs, which store results to the modelled data memory and compare them.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_LB    = 6'b100000;
  localparam logic [5:0] OP_SB    = 6'b101000;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;

  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  // Per-instruction control word produced by the decoder.
  typedef struct packed {
    logic reg_we;   // instruction writes a register
    logic dst_rd;   // destination is bits [15:11] instead of [20:16]
    logic use_imm;  // second ALU operand is the extended constant
    logic alu_sub;  // subtract instead of add
    logic mem_re;   // load
    logic mem_we;   // store
    logic mem_byte; // byte-sized access
    logic br_eq;    // branch when operands match
    logic br_ne;    // branch when operands differ
  } ctrl_t;
endpackage

// File: rtl/mc_decode.sv
`timescale 1ns/1ps
module mc_decode
  import mc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (op)
      OP_RTYPE: begin
        if (shamt == 5'd0 && (funct == FN_ADD || funct == FN_SUB)) begin
          ctrl.reg_we  = 1'b1;
          ctrl.dst_rd  = 1'b1;
          ctrl.alu_sub = (funct == FN_SUB);
        end
      end
      OP_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_LW, OP_LB: begin
        ctrl.reg_we   = 1'b1;
        ctrl.use_imm  = 1'b1;
        ctrl.mem_re   = 1'b1;
        ctrl.mem_byte = (op == OP_LB);
      end
      OP_SW, OP_SB: begin
        ctrl.use_imm  = 1'b1;
        ctrl.mem_we   = 1'b1;
        ctrl.mem_byte = (op == OP_SB);
      end
      OP_BEQ: ctrl.br_eq = 1'b1;
      OP_BNE: ctrl.br_ne = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Register 0 is never stored; its reads are forced to zero below.
  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y,
  output logic          eq
);
  assign y  = sub ? (a - b) : (a + b);
  assign eq = (a == b);
endmodule

// File: rtl/mc_pcgen.sv
`timescale 1ns/1ps
module mc_pcgen #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_eq,
  input  logic          br_ne,
  input  logic          eq,
  input  logic [DW-1:0] imm_sx,
  output logic [DW-1:0] pc
);
  localparam logic [DW-1:0] STEP = DW'(4);

  logic [DW-1:0] seq_pc;
  logic [DW-1:0] tgt_pc;
  logic          taken;

  assign seq_pc = pc + STEP;
  assign tgt_pc = seq_pc + {imm_sx[DW-3:0], 2'b00};
  assign taken  = (br_eq && eq) || (br_ne && !eq);

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= taken ? tgt_pc : seq_pc;
  end
endmodule

// File: rtl/mini_core.sv
`timescale 1ns/1ps
module mini_core
  import mc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] ls_addr,
  output logic [XLEN-1:0] ls_wdata,
  output logic            ls_we,
  output logic            ls_re,
  output logic            ls_byte,
  input  logic [XLEN-1:0] ls_rdata
);
  localparam int IMM_W = 16;
  localparam int BYTE_W = 8;

  ctrl_t             ctrl;
  logic [XLEN-1:0]   pc;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   imm_sx;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic              alu_eq;
  logic [XLEN-1:0]   load_val;
  logic [XLEN-1:0]   wb_val;
  logic [REG_AW-1:0] wb_addr;
  logic              wb_en;

  mc_decode u_dec (
    .op   (imem_data[31:26]),
    .funct(imem_data[5:0]),
    .shamt(imem_data[10:6]),
    .ctrl (ctrl)
  );

  assign imm_sx = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

  mc_regfile #(.AW(REG_AW), .DW(XLEN)) u_rf (
    .clk(clk),
    .we (wb_en),
    .wa (wb_addr),
    .wd (wb_val),
    .ra1(imem_data[25:21]),
    .ra2(imem_data[20:16]),
    .rd1(rs_val),
    .rd2(rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

  mc_alu #(.DW(XLEN)) u_alu (
    .a  (rs_val),
    .b  (alu_b),
    .sub(ctrl.alu_sub),
    .y  (alu_y),
    .eq (alu_eq)
  );

  mc_pcgen #(.DW(XLEN)) u_pc (
    .clk   (clk),
    .rst   (rst),
    .br_eq (ctrl.br_eq),
    .br_ne (ctrl.br_ne),
    .eq    (alu_eq),
    .imm_sx(imm_sx),
    .pc    (pc)
  );

  assign imem_addr = pc;

  // Write-back selection
  assign load_val = ctrl.mem_byte
                  ? {{(XLEN-BYTE_W){ls_rdata[BYTE_W-1]}}, ls_rdata[BYTE_W-1:0]}
                  : ls_rdata;
  assign wb_val  = ctrl.mem_re ? load_val : alu_y;
  assign wb_addr = ctrl.dst_rd ? imem_data[15:11] : imem_data[20:16];
  assign wb_en   = ctrl.reg_we && !rst;

  // Data port
  assign ls_addr  = alu_y;
  assign ls_wdata = ctrl.mem_byte ? {{(XLEN-BYTE_W){1'b0}}, rt_val[BYTE_W-1:0]} : rt_val;
  assign ls_we    = ctrl.mem_we && !rst;
  assign ls_re    = ctrl.mem_re && !rst;
  assign ls_byte  = ctrl.mem_byte;
endmodule

// File: rtl/mc_core_chk.sv
`timescale 1ns/1ps
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            ls_we,
  input logic            ls_re,
  input logic [XLEN-1:0] ls_addr
);
  logic [5:0]      op;
  logic [XLEN-1:0] imm_sx;
  logic            is_br;
  logic            br_take;

  assign op      = instr[31:26];
  assign imm_sx  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign is_br   = (op == OP_BEQ) || (op == OP_BNE);
  assign br_take = ((op == OP_BEQ) && (rs_val == rt_val)) ||
                   ((op == OP_BNE) && (rs_val != rt_val));

  a_r3_zero_rs: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_val == '0));

  a_r3_zero_rt: assert property (@(posedge clk) disable iff (rst)
    (instr[20:16] == 5'd0) |-> (rt_val == '0));

  a_r9_seq_pc: assert property (@(posedge clk) disable iff (rst)
    !is_br |=> (pc == $past(pc) + XLEN'(4)));

  a_r6_taken: assert property (@(posedge clk) disable iff (rst)
    br_take |=> (pc == $past(pc) + XLEN'(4) + ($past(imm_sx) << 2)));

  a_r6_fall: assert property (@(posedge clk) disable iff (rst)
    (is_br && !br_take) |=> (pc == $past(pc) + XLEN'(4)));

  a_r7_store_op: assert property (@(posedge clk) disable iff (rst)
    ls_we |-> ((op == OP_SW) || (op == OP_SB)));

  a_r4_addr: assert property (@(posedge clk) disable iff (rst)
    (ls_we || ls_re) |-> (ls_addr == rs_val + imm_sx));

  a_r8_quiet: assert property (@(posedge clk)
    rst |-> (!ls_we && !ls_re));

  a_r8_pc_zero: assert property (@(posedge clk)
    rst |=> (pc == '0));
endmodule

bind mini_core mc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .instr  (imem_data),
  .pc     (imem_addr),
  .rs_val (rs_val),
  .rt_val (rt_val),
  .ls_we  (ls_we),
  .ls_re  (ls_re),
  .ls_addr(ls_addr)
);

// File: tb/mini_core_tb.sv
`timescale 1ns/1ps
module mini_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data;
  logic [31:0] ls_addr, ls_wdata, ls_rdata;
  logic        ls_we, ls_re, ls_byte;

  int errors = 0;
  int checks = 0;
  int wr_total = 0;
  int rd_total = 0;

  logic [31:0] imem [64];
  logic [7:0]  dmem [256];

  always #5 clk = ~clk;

  mini_core u_dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .ls_addr(ls_addr), .ls_wdata(ls_wdata),
    .ls_we(ls_we), .ls_re(ls_re), .ls_byte(ls_byte),
    .ls_rdata(ls_rdata)
  );

  // Instruction and data models
  assign imem_data = imem[imem_addr[7:2]];

  logic [7:0] wbase;
  assign wbase = {ls_addr[7:2], 2'b00};
  // Byte reads return junk in [31:8] to show the core ignores it.
  assign ls_rdata = ls_byte ? {24'hA5A5A5, dmem[ls_addr[7:0]]}
                            : {dmem[wbase+8'd3], dmem[wbase+8'd2], dmem[wbase+8'd1], dmem[wbase]};

  always @(posedge clk) begin
    if (ls_we) begin
      wr_total <= wr_total + 1;
      if (ls_byte) dmem[ls_addr[7:0]] <= ls_wdata[7:0];
      else begin
        dmem[wbase]      <= ls_wdata[7:0];
        dmem[wbase+8'd1] <= ls_wdata[15:8];
        dmem[wbase+8'd2] <= ls_wdata[23:16];
        dmem[wbase+8'd3] <= ls_wdata[31:24];
      end
    end
    if (ls_re) rd_total <= rd_total + 1;
  end

  // Encoders
  function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [5:0] fn,
                                        input logic [4:0] sh);
    return {6'b000000, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt,
                                        input logic [4:0] rs, input int imm);
    logic [15:0] i16;
    i16 = 16'(imm);
    return {op, rs, rt, i16};
  endfunction

  function automatic logic [31:0] mem_word(input int a);
    return {dmem[a+3], dmem[a+2], dmem[a+1], dmem[a]};
  endfunction

  localparam logic [31:0] HALT = {6'b000100, 5'd0, 5'd0, 16'hFFFF};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_mems();
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    for (int i = 0; i < 256; i++) dmem[i] = 8'hEE;
  endtask

  task automatic run(input int n);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R8, R9: reset state and sequential fetch over no-op words
  task automatic t_reset();
    clear_mems();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8", "pc in reset", imem_addr, 32'h0);
    check("R8", "strobes in reset", {30'h0, ls_we, ls_re}, 32'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9", "pc after 1 step", imem_addr, 32'h4);
    @(posedge clk); @(negedge clk);
    check("R9", "pc after 2 steps", imem_addr, 32'h8);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8", "pc re-reset", imem_addr, 32'h0);
  endtask

  // R1, R2, R3: arithmetic and register 0
  task automatic t_arith();
    clear_mems();
    imem[0]  = enc_i(6'b001000, 5'd1, 5'd0, 5);
    imem[1]  = enc_i(6'b001000, 5'd2, 5'd0, -3);
    imem[2]  = enc_r(5'd3, 5'd1, 5'd2, 6'b100000, 5'd0);
    imem[3]  = enc_r(5'd4, 5'd1, 5'd2, 6'b100010, 5'd0);
    imem[4]  = enc_i(6'b101011, 5'd3, 5'd0, 0);
    imem[5]  = enc_i(6'b101011, 5'd4, 5'd0, 4);
    imem[6]  = enc_i(6'b001000, 5'd0, 5'd0, 7);
    imem[7]  = enc_i(6'b101011, 5'd0, 5'd0, 8);
    imem[8]  = enc_r(5'd5, 5'd2, 5'd1, 6'b100010, 5'd0);
    imem[9]  = enc_i(6'b101011, 5'd5, 5'd0, 12);
    imem[10] = HALT;
    run(16);
    check("R1", "add 5+(-3)", mem_word(0), 32'd2);
    check("R1", "sub 5-(-3)", mem_word(4), 32'd8);
    check("R3", "reg0 after write", mem_word(8), 32'h0);
    check("R2", "negative addi then sub", mem_word(12), 32'hFFFF_FFF8);
  endtask

  // R4, R5: loads and stores
  task automatic t_mem();
    clear_mems();
    dmem[16] = 8'h80; dmem[17] = 8'h56; dmem[18] = 8'h34; dmem[19] = 8'h12;
    for (int i = 40; i < 44; i++) dmem[i] = 8'hAA;
    imem[0]  = enc_i(6'b100011, 5'd5, 5'd0, 16);
    imem[1]  = enc_i(6'b101011, 5'd5, 5'd0, 20);
    imem[2]  = enc_i(6'b100000, 5'd6, 5'd0, 16);
    imem[3]  = enc_i(6'b101011, 5'd6, 5'd0, 24);
    imem[4]  = enc_i(6'b100000, 5'd7, 5'd0, 17);
    imem[5]  = enc_i(6'b101011, 5'd7, 5'd0, 28);
    imem[6]  = enc_i(6'b001000, 5'd8, 5'd0, 48);
    imem[7]  = enc_i(6'b100011, 5'd9, 5'd8, -32);
    imem[8]  = enc_i(6'b101011, 5'd9, 5'd0, 32);
    imem[9]  = enc_i(6'b101000, 5'd5, 5'd0, 41);
    imem[10] = HALT;
    run(16);
    check("R4", "load/store word", mem_word(20), 32'h1234_5680);
    check("R5", "lb negative byte", mem_word(24), 32'hFFFF_FF80);
    check("R5", "lb positive byte", mem_word(28), 32'h0000_0056);
    check("R4", "negative offset", mem_word(32), 32'h1234_5680);
    check("R5", "sb one lane", mem_word(40), 32'hAAAA_80AA);
  endtask

  // R6: loop with backward bne, forward beq, untaken bne
  task automatic t_branch();
    clear_mems();
    imem[0]  = enc_i(6'b001000, 5'd1, 5'd0, 3);
    imem[1]  = enc_i(6'b001000, 5'd2, 5'd0, 0);
    imem[2]  = enc_i(6'b001000, 5'd2, 5'd2, 2);
    imem[3]  = enc_i(6'b001000, 5'd1, 5'd1, -1);
    imem[4]  = enc_i(6'b000101, 5'd0, 5'd1, -3);
    imem[5]  = enc_i(6'b000100, 5'd0, 5'd1, 1);
    imem[6]  = enc_i(6'b001000, 5'd2, 5'd2, 100);
    imem[7]  = enc_i(6'b000101, 5'd2, 5'd2, 1);
    imem[8]  = enc_i(6'b001000, 5'd2, 5'd2, 1);
    imem[9]  = enc_i(6'b101011, 5'd2, 5'd0, 0);
    imem[10] = enc_i(6'b101011, 5'd1, 5'd0, 4);
    imem[11] = HALT;
    run(40);
    check("R6", "branch path result", mem_word(0), 32'd7);
    check("R6", "loop counter", mem_word(4), 32'd0);
    check("R6", "halt self-loop pc", imem_addr, 32'd44);
  endtask

  // R7: unsupported encodings are silent no-ops
  task automatic t_unsup();
    int w0, r0;
    clear_mems();
    imem[0] = enc_i(6'b001000, 5'd3, 5'd0, 9);
    imem[1] = enc_r(5'd3, 5'd0, 5'd0, 6'b101010, 5'd0);
    imem[2] = {6'b000010, 26'h0000_010};
    imem[3] = enc_r(5'd3, 5'd0, 5'd0, 6'b100000, 5'd1);
    imem[4] = enc_i(6'b100001, 5'd3, 5'd0, 0);
    imem[5] = enc_i(6'b101001, 5'd3, 5'd0, 4);
    imem[6] = enc_i(6'b101011, 5'd3, 5'd0, 0);
    imem[7] = HALT;
    w0 = wr_total;
    r0 = rd_total;
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R7", "pc past no-ops", imem_addr, 32'd20);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R7", "reg3 untouched", mem_word(0), 32'd9);
    check("R7", "store count", 32'(wr_total - w0), 32'd1);
    check("R7", "load count", 32'(rd_total - r0), 32'd0);
    check("R7", "no half store", mem_word(4), 32'hEEEE_EEEE);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_mem();
    t_branch();
    t_unsup();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule